// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block applies a new set of integer divider values to a PLL through the PLL's four-word control bank. A request carries a feedback divider, a reference divider and two post dividers, and is launched with a one-cycle `start` strobe. The sequencer first confirms that the request gives a legal VCO frequency, a legal output frequency and a legal feedback divider. A request that fails this check ends at once and nothing is written to the bank.

For a legal request the sequencer issues a fixed series of masked field writes. It parks the PLL in slow bypass mode, selects integer mode, writes the feedback divider, and then writes the reference divider and both post dividers. Next it polls the lock flag. Normal mode is restored only after lock is observed. A programmable timeout ends the polling when lock never arrives. In that case the PLL is left in slow mode and an error flag is raised.

The write port is a single-word master: a word index, a data word, and a per-bit enable mask that the bank applies as a read-modify-write. The read port has a fixed index and returns the status word that carries the lock flag.

Top module: `pll_prog_seq`

## Requirements
- R1: A request is rejected when any of these holds: the reference divider is 0, a post divider is 0, the exact VCO ratio 24·fb/ref MHz lies outside 800..3200, the exact output ratio VCO/(p1·p2) lies outside 16..3200 MHz, or fb lies outside 16..3200. On rejection no write is issued, `done` pulses two cycles after `start` is sampled, and `range_err` is set.
- R2: The first write of an accepted request goes to word 3, has mask bits 9:8 only, and writes the slow mode code 2'b00 into that field.
- R3: The second write goes to word 3, has mask bit 3 only, and sets bit 3 to 1, which selects integer mode.
- R4: The third write goes to word 0 and puts fb into bits 11:0.
- R5: The fourth write goes to word 1. It puts p2 into bits 14:12, p1 into bits 10:8 and the reference divider into bits 5:0.
- R6: After the divider writes, bit 31 of the read data (`rd_idx` = 2) is polled. Word 3 bits 9:8 are written to the normal code 2'b01 only in the cycle after bit 31 is seen as 1.
- R7: Every write has a non-zero mask, its data is zero outside the mask, and bank bits outside the targeted fields keep their values.
- R8: When lock is not seen within `lock_limit`+1 poll cycles, `lock_err` is set, `done` pulses, no normal-mode write is issued (so the mode stays 2'b00), and the block returns to idle.
- R9: A `start` that arrives while `busy` is high is ignored and does not change the request in flight.
- R10: `busy` goes high one cycle after an accepted `start`. `done` is a single-cycle pulse, once per accepted request, and `busy` is low while `done` is high.
- R11: After reset, `busy`, `done`, `wr_en`, `range_err` and `lock_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| req_fb | input | 12 | Requested feedback divider |
| req_rdiv | input | 6 | Requested reference divider |
| req_p1 | input | 3 | Requested first post divider |
| req_p2 | input | 3 | Requested second post divider |
| lock_limit | input | LOCK_CNT_W | Lock poll timeout, in cycles |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| range_err | output | 1 | Last request was rejected by the range check |
| lock_err | output | 1 | Last request timed out waiting for lock |
| wr_en | output | 1 | Bank write strobe |
| wr_idx | output | 2 | Bank word index |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Per-bit write enable |
| rd_idx | output | 2 | Status word index (fixed at 2) |
| rd_data | input | 32 | Status word; bit 31 is the lock flag |

## Verification
The block is driven with three legal divider sets whose lock arrives after different delays. These show that the write order and field placement do not depend on how long lock takes. Rejected requests are tried one rule at a time: a VCO below range, a feedback divider above range while the VCO and output stay legal, a zero post divider and a zero reference divider. Each case must leave the preloaded bank untouched. A PLL that never locks separates the timeout path from the normal path, and a second `start` sent in the middle of a request shows that the request in flight is not disturbed.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int WORD_W     = 32;
  localparam int IDX_W      = 2;
  localparam int FB_W       = 12;
  localparam int RDIV_W     = 6;
  localparam int PDIV_W     = 3;

  localparam logic [IDX_W-1:0] W_FB   = 2'd0;
  localparam logic [IDX_W-1:0] W_DIV  = 2'd1;
  localparam logic [IDX_W-1:0] W_STAT = 2'd2;
  localparam logic [IDX_W-1:0] W_CTL  = 2'd3;

  localparam int MODE_LSB   = 8;
  localparam int MODE_W     = 2;
  localparam int INT_BIT    = 3;
  localparam int LOCK_BIT   = 31;
  localparam int P1_LSB     = 8;
  localparam int P2_LSB     = 12;
  localparam int RDIV_LSB   = 0;
  localparam int FB_LSB     = 0;

  localparam logic [MODE_W-1:0] MODE_SLOW = 2'b00;
  localparam logic [MODE_W-1:0] MODE_NORM = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SLOW, ST_INTG, ST_FBW, ST_DIVW, ST_POLL, ST_NORM
  } seq_state_t;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] mask;
  } bank_wr_t;

  function automatic logic [WORD_W-1:0] field_mask(input int lsb, input int width);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  function automatic bank_wr_t mode_write(input logic [MODE_W-1:0] code);
    bank_wr_t w;
    w.idx  = W_CTL;
    w.mask = field_mask(MODE_LSB, MODE_W);
    w.data = WORD_W'(code) << MODE_LSB;
    return w;
  endfunction

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check
  import pll_seq_pkg::*;
#(
  parameter int REF_MHZ = 24,
  parameter int VCO_MIN = 800,
  parameter int VCO_MAX = 3200,
  parameter int OUT_MIN = 16,
  parameter int OUT_MAX = 3200,
  parameter int FB_MIN  = 16,
  parameter int FB_MAX  = 3200
) (
  input  logic [FB_W-1:0]   fb,
  input  logic [RDIV_W-1:0] rdiv,
  input  logic [PDIV_W-1:0] p1,
  input  logic [PDIV_W-1:0] p2,
  output logic              legal
);
  localparam int CW = 40;

  logic [CW-1:0] num, den_v, den_o;
  logic vco_ok, out_ok, fb_ok;

  always_comb begin
    num   = CW'(REF_MHZ) * CW'(fb);
    den_v = CW'(rdiv);
    den_o = CW'(rdiv) * CW'(p1) * CW'(p2);
    vco_ok = (den_v != '0) && (num >= CW'(VCO_MIN) * den_v) && (num <= CW'(VCO_MAX) * den_v);
    out_ok = (den_o != '0) && (num >= CW'(OUT_MIN) * den_o) && (num <= CW'(OUT_MAX) * den_o);
    fb_ok  = (int'(fb) >= FB_MIN) && (int'(fb) <= FB_MAX);
    legal  = vco_ok && out_ok && fb_ok;
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int LOCK_CNT_W = 16,
  parameter int REF_MHZ    = 24,
  parameter int VCO_MIN    = 800,
  parameter int VCO_MAX    = 3200,
  parameter int OUT_MIN    = 16,
  parameter int OUT_MAX    = 3200,
  parameter int FB_MIN     = 16,
  parameter int FB_MAX     = 3200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [11:0]           req_fb,
  input  logic [5:0]            req_rdiv,
  input  logic [2:0]            req_p1,
  input  logic [2:0]            req_p2,
  input  logic [LOCK_CNT_W-1:0] lock_limit,
  output logic                  busy,
  output logic                  done,
  output logic                  range_err,
  output logic                  lock_err,
  output logic                  wr_en,
  output logic [1:0]            wr_idx,
  output logic [31:0]           wr_data,
  output logic [31:0]           wr_mask,
  output logic [1:0]            rd_idx,
  input  logic [31:0]           rd_data
);
  seq_state_t          state;
  logic [FB_W-1:0]     q_fb;
  logic [RDIV_W-1:0]   q_rdiv;
  logic [PDIV_W-1:0]   q_p1, q_p2;
  logic [LOCK_CNT_W-1:0] q_limit;
  logic                legal, tmo, locked;
  bank_wr_t            w_intg, w_fb, w_div, w_slow, w_norm;

  pll_cfg_check #(
    .REF_MHZ(REF_MHZ), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX),
    .OUT_MIN(OUT_MIN), .OUT_MAX(OUT_MAX), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
  ) u_chk (
    .fb(q_fb), .rdiv(q_rdiv), .p1(q_p1), .p2(q_p2), .legal(legal)
  );

  pll_lock_timer #(.CNT_W(LOCK_CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .run(state == ST_POLL), .limit(q_limit), .expired(tmo)
  );

  assign rd_idx = W_STAT;
  assign locked = rd_data[LOCK_BIT];

  always_comb begin
    w_slow = mode_write(MODE_SLOW);
    w_norm = mode_write(MODE_NORM);
    w_intg.idx  = W_CTL;
    w_intg.mask = field_mask(INT_BIT, 1);
    w_intg.data = field_mask(INT_BIT, 1);
    w_fb.idx    = W_FB;
    w_fb.mask   = field_mask(FB_LSB, FB_W);
    w_fb.data   = WORD_W'(q_fb) << FB_LSB;
    w_div.idx   = W_DIV;
    w_div.mask  = field_mask(P2_LSB, PDIV_W) | field_mask(P1_LSB, PDIV_W)
                | field_mask(RDIV_LSB, RDIV_W);
    w_div.data  = (WORD_W'(q_p2) << P2_LSB) | (WORD_W'(q_p1) << P1_LSB)
                | (WORD_W'(q_rdiv) << RDIV_LSB);
  end

  task automatic issue(input bank_wr_t w);
    wr_en   <= 1'b1;
    wr_idx  <= w.idx;
    wr_data <= w.data;
    wr_mask <= w.mask;
  endtask

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      range_err <= 1'b0;
      lock_err  <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      wr_mask   <= '0;
      q_fb      <= '0;
      q_rdiv    <= '0;
      q_p1      <= '0;
      q_p2      <= '0;
      q_limit   <= '0;
    end else begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      wr_mask <= '0;
      unique case (state)
        ST_IDLE: if (start) begin
          q_fb      <= req_fb;
          q_rdiv    <= req_rdiv;
          q_p1      <= req_p1;
          q_p2      <= req_p2;
          q_limit   <= lock_limit;
          busy      <= 1'b1;
          range_err <= 1'b0;
          lock_err  <= 1'b0;
          state     <= ST_CHECK;
        end
        ST_CHECK: if (!legal) begin
          range_err <= 1'b1;
          done      <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end else begin
          issue(w_slow);
          state <= ST_SLOW;
        end
        ST_SLOW: begin issue(w_intg); state <= ST_INTG; end
        ST_INTG: begin issue(w_fb);   state <= ST_FBW;  end
        ST_FBW:  begin issue(w_div);  state <= ST_DIVW; end
        ST_DIVW: state <= ST_POLL;
        ST_POLL: if (locked) begin
          issue(w_norm);
          state <= ST_NORM;
        end else if (tmo) begin
          lock_err <= 1'b1;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        ST_NORM: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_prog_seq_sva.sv
module pll_prog_seq_sva
  import pll_seq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        range_err,
  input logic        lock_err,
  input logic        wr_en,
  input logic [1:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [31:0] wr_mask,
  input logic [31:0] rd_data
);
  localparam logic [31:0] MODE_M = field_mask(MODE_LSB, MODE_W);

  // R11
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !wr_en && !range_err && !lock_err));

  // R7
  a_r7_mask_bounds: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_mask != '0) && ((wr_data & ~wr_mask) == '0));

  // R2
  a_r2_burst_opens_on_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> (wr_idx == W_CTL) && (wr_mask == MODE_M));

  // R6
  a_r6_norm_after_lock: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == W_CTL && wr_mask == MODE_M
     && wr_data[MODE_LSB +: MODE_W] == MODE_NORM) |-> $past(rd_data[LOCK_BIT]));

  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1
  a_r1_reject_silent: assert property (@(posedge clk) disable iff (rst)
    range_err |-> !wr_en);

  // R8
  a_r8_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(range_err && lock_err));

  // R9
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));
endmodule

bind pll_prog_seq pll_prog_seq_sva u_sva (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .range_err(range_err), .lock_err(lock_err), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data)
);

// File: tb/pll_prog_seq_tb.sv
module pll_prog_seq_tb;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [11:0] req_fb = '0;
  logic [5:0]  req_rdiv = '0;
  logic [2:0]  req_p1 = '0, req_p2 = '0;
  logic [LW-1:0] lock_limit = '0;
  logic busy, done, range_err, lock_err, wr_en;
  logic [1:0] wr_idx, rd_idx;
  logic [31:0] wr_data, wr_mask, rd_data;

  int checks = 0, fails = 0, cyc = 0, ndone = 0;
  int ldly = 3;

  always #10 clk = ~clk;

  pll_prog_seq #(.LOCK_CNT_W(LW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .req_fb(req_fb), .req_rdiv(req_rdiv),
    .req_p1(req_p1), .req_p2(req_p2), .lock_limit(lock_limit),
    .busy(busy), .done(done), .range_err(range_err), .lock_err(lock_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // ---- behavioural PLL control bank with lock delay ----
  logic [31:0] bank [4];
  logic [31:0] snap [4];
  logic locked = 1'b0, arm = 1'b0;
  int lcnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      bank[0] <= 32'hA5A5_5000; bank[1] <= 32'h5A5A_80C0;
      bank[2] <= 32'h0F0F_1234; bank[3] <= 32'hC3C3_3674;
      locked <= 1'b0; arm <= 1'b0; lcnt <= 0;
    end else begin
      if (wr_en) bank[wr_idx] <= (bank[wr_idx] & ~wr_mask) | (wr_data & wr_mask);
      if (wr_en && wr_idx == 2'd1) begin
        locked <= 1'b0; arm <= 1'b1; lcnt <= 0;
      end else if (arm && ldly >= 0) begin
        if (lcnt >= ldly) locked <= 1'b1;
        else lcnt <= lcnt + 1;
      end
    end
  end
  assign rd_data = (rd_idx == 2'd2) ? {locked, bank[2][30:0]} : bank[rd_idx];

  // ---- reference model ----
  int ph = 0, pc = 0, m_fb = 0, m_rd = 0, m_p1 = 0, m_p2 = 0, m_lim = 0;
  logic e_busy = 0, e_done = 0, e_rerr = 0, e_lerr = 0, e_wen = 0;
  logic [1:0] e_idx = 0;
  logic [31:0] e_data = 0, e_mask = 0;

  function automatic bit legal_req(int f, int r, int a, int b);
    real v, o;
    if (r == 0 || a == 0 || b == 0) return 1'b0;
    v = 24.0 * f / r;
    o = v / (a * b);
    return (v >= 800.0) && (v <= 3200.0) && (o >= 16.0) && (o <= 3200.0)
        && (f >= 16) && (f <= 3200);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph <= 0; pc <= 0; e_busy <= 0; e_done <= 0; e_rerr <= 0; e_lerr <= 0;
      e_wen <= 0; e_idx <= 0; e_data <= 0; e_mask <= 0;
    end else begin
      e_done <= 0; e_wen <= 0; e_idx <= 0; e_data <= 0; e_mask <= 0;
      case (ph)
        0: if (start) begin
          m_fb <= int'(req_fb); m_rd <= int'(req_rdiv);
          m_p1 <= int'(req_p1); m_p2 <= int'(req_p2); m_lim <= int'(lock_limit);
          e_busy <= 1; e_rerr <= 0; e_lerr <= 0; ph <= 1;
        end
        1: if (!legal_req(m_fb, m_rd, m_p1, m_p2)) begin
          e_rerr <= 1; e_done <= 1; e_busy <= 0; ph <= 0;
        end else begin
          e_wen <= 1; e_idx <= 3; e_data <= 32'h0; e_mask <= 32'h300; ph <= 2;
        end
        2: begin e_wen <= 1; e_idx <= 3; e_data <= 32'h8; e_mask <= 32'h8; ph <= 3; end
        3: begin e_wen <= 1; e_idx <= 0; e_data <= m_fb; e_mask <= 32'hFFF; ph <= 4; end
        4: begin
          e_wen <= 1; e_idx <= 1; e_mask <= 32'h773F;
          e_data <= (m_p2 << 12) | (m_p1 << 8) | m_rd; ph <= 5;
        end
        5: begin ph <= 6; pc <= 0; end
        6: if (rd_data[31]) begin
          e_wen <= 1; e_idx <= 3; e_data <= 32'h100; e_mask <= 32'h300; ph <= 7;
        end else if (pc >= m_lim) begin
          e_lerr <= 1; e_done <= 1; e_busy <= 0; ph <= 0;
        end else pc <= pc + 1;
        default: begin e_done <= 1; e_busy <= 0; ph <= 0; end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done === 1'b1) ndone <= ndone + 1;
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk("R10 busy", {31'b0, busy}, {31'b0, e_busy});
      chk("R10 done", {31'b0, done}, {31'b0, e_done});
      chk("R1 range_err", {31'b0, range_err}, {31'b0, e_rerr});
      chk("R8 lock_err", {31'b0, lock_err}, {31'b0, e_lerr});
      chk("R7 wr_en", {31'b0, wr_en}, {31'b0, e_wen});
      if (e_wen) begin
        chk("R7 wr_idx", {30'b0, wr_idx}, {30'b0, e_idx});
        chk("R7 wr_data", wr_data, e_data);
        chk("R7 wr_mask", wr_mask, e_mask);
      end
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic take_snap();
    for (int i = 0; i < 4; i++) snap[i] = bank[i];
  endtask

  task automatic launch(input int f, input int r, input int a, input int b,
                        input int dly, input int lim);
    @(negedge clk);
    take_snap();
    req_fb = 12'(f); req_rdiv = 6'(r); req_p1 = 3'(a); req_p2 = 3'(b);
    lock_limit = LW'(lim); ldly = dly; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(tag, {31'b0, seen}, 32'd1);
  endtask

  task automatic expect_programmed(input int f, input int r, input int a, input int b);
    @(negedge clk);
    chk("R4 fb field", bank[0], (snap[0] & ~32'hFFF) | f);
    chk("R5 div fields", bank[1], (snap[1] & ~32'h773F) | (b << 12) | (a << 8) | r);
    chk("R3 int bit", {31'b0, bank[3][3]}, 32'd1);
    chk("R6 normal mode", {30'b0, bank[3][9:8]}, 32'd1);
    chk("R7 ctl others kept", bank[3] & ~32'h308, snap[3] & ~32'h308);
    chk("R7 stat word kept", bank[2], snap[2]);
  endtask

  task automatic expect_rejected();
    @(negedge clk);
    chk("R1 range_err set", {31'b0, range_err}, 32'd1);
    for (int i = 0; i < 4; i++) chk("R1 bank untouched", bank[i], snap[i]);
  endtask

  int nd0;

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 busy at reset", {31'b0, busy}, 32'd0);
    chk("R11 wr_en at reset", {31'b0, wr_en}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", {29'b0, done, range_err, lock_err}, 32'd0);

    launch(100, 2, 2, 1, 3, 50);
    chk("R10 busy after start", {31'b0, busy}, 32'd1);
    wait_done("R2 request A done");
    expect_programmed(100, 2, 2, 1);

    launch(50, 1, 6, 1, 0, 50);
    wait_done("R5 request B done");
    expect_programmed(50, 1, 6, 1);

    launch(116, 1, 3, 1, 20, 50);
    wait_done("R6 request C done");
    expect_programmed(116, 1, 3, 1);

    launch(30, 1, 2, 1, 3, 50);
    wait_done("R1 vco low done");
    expect_rejected();
    launch(3300, 30, 1, 1, 3, 50);
    wait_done("R1 fb high done");
    expect_rejected();
    launch(100, 2, 0, 1, 3, 50);
    wait_done("R1 p1 zero done");
    expect_rejected();
    launch(100, 0, 2, 1, 3, 50);
    wait_done("R1 rdiv zero done");
    expect_rejected();

    launch(90, 1, 2, 2, -1, 5);
    wait_done("R8 timeout done");
    @(negedge clk);
    chk("R8 lock_err set", {31'b0, lock_err}, 32'd1);
    chk("R8 mode stays slow", {30'b0, bank[3][9:8]}, 32'd0);
    chk("R8 idle", {31'b0, busy}, 32'd0);

    nd0 = ndone;
    launch(120, 2, 2, 1, 10, 50);
    repeat (3) @(negedge clk);
    req_fb = 12'd200; req_rdiv = 6'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9 first request done");
    expect_programmed(120, 2, 2, 1);
    repeat (6) @(negedge clk);
    chk("R9 one done only", ndone - nd0, 32'd1);
    chk("R9 stays idle", {31'b0, busy}, 32'd0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule